// File: doc/BRIEF.md
# Converter Control Register Bank

This block is the host-facing register file of a converter data path. A host processor issues single-cycle read and write strobes with a small address and a group select. The block decodes them into a bank of 16-bit registers: a digital I/O word and its control word, the interrupt start and period counts, and the ADC and DAC sample-rate dividers. It also gives read-only views of three externally kept down counters and a status word of sticky FIFO error flags.

One address in the converter group is a data port, and the bus direction decides which FIFO it reaches. A read of that address pops the ADC FIFO and returns the head word. A write pushes the bus data into the DAC FIFO. The FIFOs, the counters and the converters sit outside the block and connect through plain ports.

The bank works with either of two host addressing styles, chosen by a parameter. In word mode the offset is taken from the low address bits. In byte mode each register sits 4 bytes apart, and address bits 1:0 are dropped.

Top module: `cvt_regbank`

## Requirements
- R1: After reset, every read/write register output is 0x0000, `bus_rdata` is 0x0000 and the status word reads 0x0000.
- R2: In the control group (`bus_sel_ctl`=1), offset 0 holds the digital I/O word and offset 1 holds its control word. In the converter group (`bus_sel_ctl`=0), offset 1 is interrupt start, offset 2 is interrupt period, offset 4 is the ADC rate and offset 6 is the DAC rate. A write updates the matching output at the next clock edge. A read returns the stored word on `bus_rdata` one cycle after the read strobe.
- R3: The same offset selects different registers in the two groups. Offset 0 reads the digital I/O word when `bus_sel_ctl`=1 and the status word when `bus_sel_ctl`=0.
- R4: Writes to the read-only converter offsets leave every register and the status word unchanged. Those offsets are 0 (status), 3, 5 and 7.
- R5: A read of converter offset 3 returns `irq_cnt_i`, offset 5 returns `adc_cnt_i` and offset 7 returns `dac_cnt_i`. Each is the value sampled in the read-strobe cycle.
- R6: A read of an unmapped offset returns 0x0000. The unmapped offsets are 2 to 15 in the control group and 9 to 15 in the converter group. A write to an unmapped offset changes nothing.
- R7: Converter offset 8 is the data port. A read there raises `adc_fifo_pop_o` in the strobe cycle and returns that cycle's `adc_fifo_rdata_i` one cycle later. A write there raises `dac_fifo_push_o` in the strobe cycle, with `dac_fifo_wdata_o` equal to `bus_wdata`. Neither strobe is raised at any other address.
- R8: The status word carries error flags, where 1 means an error. Bit 0 is ADC FIFO overflow, bit 1 is ADC FIFO underflow, bit 8 is DAC FIFO overflow and bit 9 is DAC FIFO underflow. All other bits read 0. A one-cycle pulse on an error input sets its flag, and the flag stays set until the status word is read.
- R9: A read of the status word returns the flags and clears them at the same edge. A pulse that arrives in the same cycle as that read is kept and shows on the next status read.
- R10: Address bits above the decoded offset are ignored.
- R11: With `BYTE_ADDR`=1 the offset is taken from address bits 5:2, and bits 1:0 are ignored. For example, byte address 0x08 reaches interrupt period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_ctl | input | 1 | 1 selects the control group, 0 selects the converter/data group |
| bus_addr | input | ADDR_W | Host address |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the read strobe |
| irq_cnt_i | input | 16 | Interrupt down counter value |
| adc_cnt_i | input | 16 | ADC clock down counter value |
| dac_cnt_i | input | 16 | DAC clock down counter value |
| adc_fifo_rdata_i | input | 16 | Head word of the ADC FIFO |
| adc_fifo_pop_o | output | 1 | ADC FIFO pop strobe |
| dac_fifo_wdata_o | output | 16 | Word pushed into the DAC FIFO |
| dac_fifo_push_o | output | 1 | DAC FIFO push strobe |
| adc_ovf_i | input | 1 | ADC FIFO overflow pulse |
| adc_udf_i | input | 1 | ADC FIFO underflow pulse |
| dac_ovf_i | input | 1 | DAC FIFO overflow pulse |
| dac_udf_i | input | 1 | DAC FIFO underflow pulse |
| dio_o | output | 16 | Digital I/O word |
| dio_ctl_o | output | 16 | Digital I/O control word |
| irq_start_o | output | 16 | Interrupt start count |
| irq_period_o | output | 16 | Interrupt period count |
| adc_rate_o | output | 16 | ADC sample-rate divider |
| dac_rate_o | output | 16 | DAC sample-rate divider |

## Verification
The FIFO strobes are combinational in the strobe cycle, so the bench samples them one time unit after it drives the strobe, before the next rising edge. Register outputs and `bus_rdata` are registered once. The bench samples them at the falling edge after the capturing rising edge, which is one cycle after the strobe. Status flags land one edge after their pulse and clear at the edge that captures a status read. The coincident-pulse case is therefore checked over two reads: the first returns the old value and the second shows the new flag.

// File: rtl/cvt_regbank_pkg.sv
package cvt_regbank_pkg;

    localparam int DATA_W = 16;
    localparam int OFF_W  = 4;

    typedef logic [DATA_W-1:0] word_t;

    // Status bit positions (decoded by host software)
    localparam int ST_ADC_OVF = 0;
    localparam int ST_ADC_UDF = 1;
    localparam int ST_DAC_OVF = 8;
    localparam int ST_DAC_UDF = 9;

    // Converter-group word offsets
    localparam logic [OFF_W-1:0] CV_STATUS  = 4'd0;
    localparam logic [OFF_W-1:0] CV_IRQ_ST  = 4'd1;
    localparam logic [OFF_W-1:0] CV_IRQ_PER = 4'd2;
    localparam logic [OFF_W-1:0] CV_IRQ_CNT = 4'd3;
    localparam logic [OFF_W-1:0] CV_ADC_RT  = 4'd4;
    localparam logic [OFF_W-1:0] CV_ADC_CNT = 4'd5;
    localparam logic [OFF_W-1:0] CV_DAC_RT  = 4'd6;
    localparam logic [OFF_W-1:0] CV_DAC_CNT = 4'd7;
    localparam logic [OFF_W-1:0] CV_DATA    = 4'd8;
    // Control-group word offsets
    localparam logic [OFF_W-1:0] CT_DIO     = 4'd0;
    localparam logic [OFF_W-1:0] CT_DIO_CTL = 4'd1;

    typedef struct packed {
        logic dio;
        logic dio_ctl;
        logic status;
        logic irq_start;
        logic irq_period;
        logic irq_cnt;
        logic adc_rate;
        logic adc_cnt;
        logic dac_rate;
        logic dac_cnt;
        logic data;
        logic ro;
        logic unmapped;
    } hit_t;

    typedef struct packed {
        word_t dio;
        word_t dio_ctl;
        word_t irq_start;
        word_t irq_period;
        word_t adc_rate;
        word_t dac_rate;
    } rw_t;

endpackage

// File: rtl/cvt_addr_decode.sv
module cvt_addr_decode
    import cvt_regbank_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter bit BYTE_ADDR = 1'b0
) (
    input  logic              sel_ctl,
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit_o
);
    localparam int LSB = BYTE_ADDR ? 2 : 0;

    logic [OFF_W-1:0] off;
    logic             addr_unused;

    generate
        if (BYTE_ADDR) begin : g_byte
            assign off = addr[OFF_W+1:2];
        end else begin : g_word
            assign off = addr[OFF_W-1:0];
        end
    endgenerate

    // Remaining bits are don't-care; fold them so no bit is left dangling.
    assign addr_unused = ^addr;

    always_comb begin
        hit_o = '0;
        if (sel_ctl) begin
            hit_o.dio     = (off == CT_DIO);
            hit_o.dio_ctl = (off == CT_DIO_CTL);
        end else begin
            hit_o.status     = (off == CV_STATUS);
            hit_o.irq_start  = (off == CV_IRQ_ST);
            hit_o.irq_period = (off == CV_IRQ_PER);
            hit_o.irq_cnt    = (off == CV_IRQ_CNT);
            hit_o.adc_rate   = (off == CV_ADC_RT);
            hit_o.adc_cnt    = (off == CV_ADC_CNT);
            hit_o.dac_rate   = (off == CV_DAC_RT);
            hit_o.dac_cnt    = (off == CV_DAC_CNT);
            hit_o.data       = (off == CV_DATA);
        end
        hit_o.ro = hit_o.status | hit_o.irq_cnt | hit_o.adc_cnt | hit_o.dac_cnt;
        hit_o.unmapped = ~(hit_o.dio | hit_o.dio_ctl | hit_o.irq_start
                         | hit_o.irq_period | hit_o.adc_rate | hit_o.dac_rate
                         | hit_o.data | hit_o.ro);
    end

    initial begin
        assert (LSB + OFF_W <= ADDR_W) else $error("address too narrow for offset");
    end

endmodule

// File: rtl/cvt_rw_regs.sv
module cvt_rw_regs
    import cvt_regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr,
    input  hit_t  hit,
    input  word_t wdata,
    output rw_t   rw_o
);
    rw_t rw_d, rw_q;

    always_comb begin
        rw_d = rw_q;
        if (wr) begin
            if (hit.dio)        rw_d.dio        = wdata;
            if (hit.dio_ctl)    rw_d.dio_ctl    = wdata;
            if (hit.irq_start)  rw_d.irq_start  = wdata;
            if (hit.irq_period) rw_d.irq_period = wdata;
            if (hit.adc_rate)   rw_d.adc_rate   = wdata;
            if (hit.dac_rate)   rw_d.dac_rate   = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rw_q <= '0;
        else        rw_q <= rw_d;
    end

    assign rw_o = rw_q;

    // R2: a write to the digital I/O offset lands at the next edge
    p_dio_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr && hit.dio |=> rw_q.dio == $past(wdata));

    // R6: writes that hit nothing leave storage unchanged
    p_unmapped_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr && hit.unmapped |=> $stable(rw_q));

endmodule

// File: rtl/cvt_status_flags.sv
module cvt_status_flags
    import cvt_regbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] err_pulse,   // {dac_udf, dac_ovf, adc_udf, adc_ovf}
    input  logic       clr,
    output word_t      status_o
);
    typedef struct packed {
        logic [3:0] flags;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.flags = '0;
        st_d.flags = st_d.flags | err_pulse;  // new events win over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_o = '0;
        status_o[ST_ADC_OVF] = st_q.flags[0];
        status_o[ST_ADC_UDF] = st_q.flags[1];
        status_o[ST_DAC_OVF] = st_q.flags[2];
        status_o[ST_DAC_UDF] = st_q.flags[3];
    end

    // R8: a set flag stays set while no read clears it
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((st_q.flags & $past(st_q.flags)) == $past(st_q.flags)));

    // R9: a clear with no coincident pulse leaves all flags low
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr && err_pulse == 4'b0 |=> st_q.flags == 4'b0);

    // R9: a pulse coincident with the clear survives
    p_keep_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr && err_pulse != 4'b0 |=> st_q.flags == $past(err_pulse));

endmodule

// File: rtl/cvt_regbank.sv
module cvt_regbank
    import cvt_regbank_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter bit BYTE_ADDR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_ctl,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [15:0]       irq_cnt_i,
    input  logic [15:0]       adc_cnt_i,
    input  logic [15:0]       dac_cnt_i,
    input  logic [15:0]       adc_fifo_rdata_i,
    output logic              adc_fifo_pop_o,
    output logic [15:0]       dac_fifo_wdata_o,
    output logic              dac_fifo_push_o,
    input  logic              adc_ovf_i,
    input  logic              adc_udf_i,
    input  logic              dac_ovf_i,
    input  logic              dac_udf_i,
    output logic [15:0]       dio_o,
    output logic [15:0]       dio_ctl_o,
    output logic [15:0]       irq_start_o,
    output logic [15:0]       irq_period_o,
    output logic [15:0]       adc_rate_o,
    output logic [15:0]       dac_rate_o
);
    hit_t  hit;
    rw_t   rw;
    word_t status;
    word_t rdata_d, rdata_q;
    logic  st_clr;

    cvt_addr_decode #(.ADDR_W(ADDR_W), .BYTE_ADDR(BYTE_ADDR)) u_dec (
        .sel_ctl (bus_sel_ctl),
        .addr    (bus_addr),
        .hit_o   (hit)
    );

    cvt_rw_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .hit   (hit),
        .wdata (bus_wdata),
        .rw_o  (rw)
    );

    assign st_clr = bus_rd & hit.status;

    cvt_status_flags u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_pulse ({dac_udf_i, dac_ovf_i, adc_udf_i, adc_ovf_i}),
        .clr       (st_clr),
        .status_o  (status)
    );

    // Read mux, registered once
    always_comb begin
        rdata_d = rdata_q;
        if (bus_rd) begin
            rdata_d = '0;
            if (hit.dio)        rdata_d = rw.dio;
            if (hit.dio_ctl)    rdata_d = rw.dio_ctl;
            if (hit.status)     rdata_d = status;
            if (hit.irq_start)  rdata_d = rw.irq_start;
            if (hit.irq_period) rdata_d = rw.irq_period;
            if (hit.irq_cnt)    rdata_d = irq_cnt_i;
            if (hit.adc_rate)   rdata_d = rw.adc_rate;
            if (hit.adc_cnt)    rdata_d = adc_cnt_i;
            if (hit.dac_rate)   rdata_d = rw.dac_rate;
            if (hit.dac_cnt)    rdata_d = dac_cnt_i;
            if (hit.data)       rdata_d = adc_fifo_rdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata        = rdata_q;
    assign adc_fifo_pop_o   = bus_rd & hit.data;
    assign dac_fifo_push_o  = bus_wr & hit.data;
    assign dac_fifo_wdata_o = bus_wdata;

    assign dio_o        = rw.dio;
    assign dio_ctl_o    = rw.dio_ctl;
    assign irq_start_o  = rw.irq_start;
    assign irq_period_o = rw.irq_period;
    assign adc_rate_o   = rw.adc_rate;
    assign dac_rate_o   = rw.dac_rate;

    // R6: unmapped reads return zero
    p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && hit.unmapped |=> bus_rdata == 16'h0000);

    // R4: read-only writes leave the register bank untouched
    p_ro_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && hit.ro |=> $stable(rw));

    // R8: reserved status bits read as zero
    p_status_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && hit.status |=> (bus_rdata & 16'hFCFC) == 16'h0000);

    // R7: FIFO strobes only at the converter-group data port
    p_fifo_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_fifo_pop_o || dac_fifo_push_o) |-> !bus_sel_ctl);

    // R5: counter views follow their inputs
    p_cnt_view_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && hit.adc_cnt |=> bus_rdata == $past(adc_cnt_i));

endmodule

// File: tb/cvt_regbank_tb_top.sv
module cvt_regbank_tb_top;
    localparam int ADDR_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              sel_ctl = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [ADDR_W-1:0] b_addr = '0;
    logic              rd = 1'b0, wr = 1'b0;
    logic [15:0]       wdata = '0;
    logic [15:0]       irq_cnt = 16'h1111, adc_cnt = 16'h2222, dac_cnt = 16'h3333;
    logic [15:0]       fifo_head = 16'hA5A5;
    logic              a_ovf = 0, a_udf = 0, d_ovf = 0, d_udf = 0;

    logic [15:0] rdata, dac_wd, dio, dioc, ist, iper, art, drt;
    logic        pop, push;
    logic [15:0] b_rdata, b_dac_wd, b_dio, b_dioc, b_ist, b_iper, b_art, b_drt;
    logic        b_pop, b_push;

    cvt_regbank #(.ADDR_W(ADDR_W), .BYTE_ADDR(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel_ctl(sel_ctl), .bus_addr(addr),
        .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_cnt_i(irq_cnt), .adc_cnt_i(adc_cnt), .dac_cnt_i(dac_cnt),
        .adc_fifo_rdata_i(fifo_head), .adc_fifo_pop_o(pop),
        .dac_fifo_wdata_o(dac_wd), .dac_fifo_push_o(push),
        .adc_ovf_i(a_ovf), .adc_udf_i(a_udf), .dac_ovf_i(d_ovf), .dac_udf_i(d_udf),
        .dio_o(dio), .dio_ctl_o(dioc), .irq_start_o(ist), .irq_period_o(iper),
        .adc_rate_o(art), .dac_rate_o(drt));

    cvt_regbank #(.ADDR_W(ADDR_W), .BYTE_ADDR(1'b1)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .bus_sel_ctl(sel_ctl), .bus_addr(b_addr),
        .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(b_rdata),
        .irq_cnt_i(irq_cnt), .adc_cnt_i(adc_cnt), .dac_cnt_i(dac_cnt),
        .adc_fifo_rdata_i(fifo_head), .adc_fifo_pop_o(b_pop),
        .dac_fifo_wdata_o(b_dac_wd), .dac_fifo_push_o(b_push),
        .adc_ovf_i(a_ovf), .adc_udf_i(a_udf), .dac_ovf_i(d_ovf), .dac_udf_i(d_udf),
        .dio_o(b_dio), .dio_ctl_o(b_dioc), .irq_start_o(b_ist), .irq_period_o(b_iper),
        .adc_rate_o(b_art), .dac_rate_o(b_drt));

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic s, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        sel_ctl = s; addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bread(input logic s, input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        sel_ctl = s; addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    function automatic logic [15:0] rw_sel(input int i);
        case (i)
            0: return dio;   1: return dioc; 2: return ist;
            3: return iper;  4: return art;  default: return drt;
        endcase
    endfunction

    typedef struct packed {
        logic        sel;
        logic [7:0]  adr;
        logic [15:0] val;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b1, 8'h00, 16'h0001},
        '{1'b1, 8'h01, 16'h3000},
        '{1'b0, 8'h01, 16'h0100},
        '{1'b0, 8'h02, 16'h0180},
        '{1'b0, 8'h04, 16'h0009},
        '{1'b0, 8'h06, 16'h0013}
    };

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 dio", dio, 16'h0); check("R1 dac_rate", drt, 16'h0);
        check("R1 rdata", rdata, 16'h0);
        rst_n = 1'b1;
        bread(1'b0, 8'h00, r); check("R1 status", r, 16'h0);

        // R2: vector table write, then output and read-back checks
        for (int i = 0; i < 6; i++) bwrite(VEC[i].sel, VEC[i].adr, VEC[i].val);
        for (int i = 0; i < 6; i++) begin
            check("R2 output", rw_sel(i), VEC[i].val);
            bread(VEC[i].sel, VEC[i].adr, r);
            check("R2 readback", r, VEC[i].val);
        end

        // R3: offset 0 aliases differ by group
        bread(1'b1, 8'h00, r); check("R3 ctl off0", r, 16'h0001);
        a_ovf = 1'b0;
        bread(1'b0, 8'h00, r); check("R3 cvt off0", r, 16'h0000);

        // R4: writes to read-only offsets ignored
        bwrite(1'b0, 8'h00, 16'hFFFF); bwrite(1'b0, 8'h03, 16'hFFFF);
        bwrite(1'b0, 8'h05, 16'hFFFF); bwrite(1'b0, 8'h07, 16'hFFFF);
        for (int i = 0; i < 6; i++) check("R4 regs unchanged", rw_sel(i), VEC[i].val);
        bread(1'b0, 8'h00, r); check("R4 status unchanged", r, 16'h0000);

        // R5: counter views
        bread(1'b0, 8'h03, r); check("R5 irq cnt", r, 16'h1111);
        bread(1'b0, 8'h05, r); check("R5 adc cnt", r, 16'h2222);
        dac_cnt = 16'h7E57;
        bread(1'b0, 8'h07, r); check("R5 dac cnt", r, 16'h7E57);

        // R6: unmapped reads and writes
        bread(1'b1, 8'h02, r); check("R6 ctl off2", r, 16'h0000);
        bread(1'b1, 8'h07, r); check("R6 ctl off7", r, 16'h0000);
        bread(1'b0, 8'h09, r); check("R6 cvt off9", r, 16'h0000);
        bread(1'b0, 8'h0F, r); check("R6 cvt off15", r, 16'h0000);
        bwrite(1'b1, 8'h05, 16'hDEAD); bwrite(1'b0, 8'h0C, 16'hBEEF);
        for (int i = 0; i < 6; i++) check("R6 write ignored", rw_sel(i), VEC[i].val);

        // R7: data port read pops ADC FIFO, write pushes DAC FIFO
        @(negedge clk); sel_ctl = 1'b0; addr = 8'h08; rd = 1'b1; fifo_head = 16'hC0DE;
        #1 check("R7 pop", {15'b0, pop}, 16'h1); check("R7 no push", {15'b0, push}, 16'h0);
        @(negedge clk); rd = 1'b0; fifo_head = 16'h0BAD;
        check("R7 adc data", rdata, 16'hC0DE);
        @(negedge clk); addr = 8'h08; wdata = 16'h5A5A; wr = 1'b1;
        #1 check("R7 push", {15'b0, push}, 16'h1); check("R7 push data", dac_wd, 16'h5A5A);
        check("R7 no pop", {15'b0, pop}, 16'h0);
        @(negedge clk); wr = 1'b0;
        @(negedge clk); addr = 8'h02; rd = 1'b1;
        #1 check("R7 no pop elsewhere", {15'b0, pop}, 16'h0);
        @(negedge clk); rd = 1'b0;

        // R8: flag positions and stickiness
        @(negedge clk); a_ovf = 1'b1; @(negedge clk); a_ovf = 1'b0;
        repeat (3) @(negedge clk);
        bread(1'b0, 8'h00, r); check("R8 adc ovf bit0", r, 16'h0001);
        @(negedge clk); a_ovf = 1; a_udf = 1; d_ovf = 1; d_udf = 1;
        @(negedge clk); a_ovf = 0; a_udf = 0; d_ovf = 0; d_udf = 0;
        bread(1'b0, 8'h00, r); check("R8 all flags", r, 16'h0303);

        // R9: read clears; coincident pulse kept
        bread(1'b0, 8'h00, r); check("R9 cleared", r, 16'h0000);
        @(negedge clk); sel_ctl = 1'b0; addr = 8'h00; rd = 1'b1; d_ovf = 1'b1;
        @(negedge clk); rd = 1'b0; d_ovf = 1'b0;
        check("R9 coincident read old", rdata, 16'h0000);
        bread(1'b0, 8'h00, r); check("R9 coincident kept", r, 16'h0100);

        // R10: upper address bits ignored
        bwrite(1'b1, 8'hF1, 16'h4242); check("R10 upper bits", dioc, 16'h4242);
        bread(1'b0, 8'hA4, r); check("R10 upper bits read", r, 16'h0009);

        // R11: byte-addressed variant
        @(negedge clk); sel_ctl = 1'b0; b_addr = 8'h8B; addr = 8'h0F; wdata = 16'h0777; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        check("R11 byte write", b_iper, 16'h0777);
        @(negedge clk); b_addr = 8'h08; rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        check("R11 byte read", b_rdata, 16'h0777);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule